// File: doc/BRIEF.md
# SPI Register Frame Master

This block drives an SPI bus as master and runs one register or buffer access per chip-select window against a peripheral that expects a three-byte header. A request names a 16-bit offset, a 5-bit block select, a direction and a byte count. The master opens the frame and sends the offset (high byte, then low byte). It then sends a control byte that packs the block select, the direction and a length mode. After the header it either streams write bytes from a ready/valid input or clocks in read bytes onto a ready/valid output.

A frame of one byte uses the fixed single-byte length mode. Any longer access uses the variable mode, and in that mode the peripheral learns the length only from how long chip select stays low. The bus runs in SPI mode 0, and the serial clock is the system clock divided by the even parameter `CLK_DIV`. If either byte stream stalls, the serial clock is held low and the frame is not closed. A request with a count of zero is refused and reported.

Top module: `spi_frame_master`

## Requirements
- R1: `csN` goes low when a request with a non-zero length is accepted and stays low until the last data bit has been shifted. A frame holds exactly 3+N bytes (8·(3+N) rising `sclk` edges). `sclk` never rises while `csN` is high, and `reqReady` is low while a frame is in progress.
- R2: The first header byte is `reqAddr[15:8]` and the second is `reqAddr[7:0]`.
- R3: The third header byte is `{reqBlock[4:0], reqWrite, lenMode[1:0]}`. Bit 2 is the direction, with 1 meaning write. lenMode is 2'b01 when the length is 1 and 2'b00 otherwise, so a one-byte write sends low bits 101 and a one-byte read sends 001.
- R4: In a write frame, the N bytes accepted on `wrData` (each on a cycle with `wrValid` and `wrReady` both high) follow the header in the order they were accepted. `wrReady` is only ever high while `csN` is low.
- R5: In a read frame, 0x00 is shifted out for each of the N data bytes. Each byte captured from `miso` is presented on `rdData` with `rdValid` high, and both hold unchanged until `rdReady` is seen.
- R6: A request with `reqLen` of 0 is consumed, raises `lenError` for exactly one cycle and does not start a frame: `csN` stays high and `sclk` does not toggle.
- R7: SPI mode 0 applies: `sclk` idles low, `mosi` changes only while `sclk` is low, the master samples `miso` at each rising `sclk` edge, and every byte goes out most significant bit first.
- R8: Each high phase of `sclk` lasts exactly CLK_DIV/2 system cycles. Each low phase lasts at least CLK_DIV/2 cycles, and longer while a byte stream stalls.
- R9: `busy` is high from the cycle `csN` falls until CLK_DIV cycles after `csN` rises. `reqReady` equals `!busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqAddr | input | 16 | Register or buffer offset |
| reqBlock | input | 5 | Block select placed in the control byte |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqLen | input | LEN_W | Number of data bytes |
| wrValid | input | 1 | Write byte offered |
| wrReady | output | 1 | Write byte taken when high with wrValid |
| wrData | input | 8 | Write byte |
| rdValid | output | 1 | Read byte available |
| rdReady | input | 1 | Read byte consumed when high with rdValid |
| rdData | output | 8 | Read byte |
| lenError | output | 1 | One-cycle pulse on a zero-length request |
| busy | output | 1 | Frame in progress or trailing idle period |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The bench's slave model decodes each header and holds a small memory. The one-byte frame is the main trap for the length-mode field: a design that always sent the burst mode would fail the control-byte compare on every single-byte access, and one that always sent the single mode would fail it on every burst. Bursts that run past the end of the slave's memory, together with random stalls on both byte streams, catch a master that drops or repeats a byte, or lets `sclk` run while a stream is empty. A later read-back of written bytes would then mismatch. A zero-length request must give an error pulse and no chip-select edge, and the idle period after each frame is counted so that a `busy` that drops early or late is reported.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  // Strobes from the sequencer to the shift datapath.
  typedef struct packed {
    logic       load;      // preload a new byte, restart bit and phase counters
    logic       run;       // let the divider advance and toggle sclk
    logic [7:0] loadByte;  // byte to shift out
  } sfmStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_SHIFT,
    ST_WAITWR,
    ST_RDOUT,
    ST_GAP
  } sfmState_t;

  localparam logic [1:0] MODE_BURST  = 2'b00;
  localparam logic [1:0] MODE_SINGLE = 2'b01;
  localparam int         HDR_BYTES   = 3;

endpackage

// File: rtl/sfm_datapath.sv
module sfm_datapath
  import sfm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  sfmStrobe_t strobe,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte
);

  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] halfCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    txShift;
  logic [7:0]    rxShift;
  logic          sclkQ;
  logic          edgeTick;

  assign edgeTick = strobe.run && (halfCnt == HW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      bitCnt  <= '0;
      txShift <= '0;
      rxShift <= '0;
      sclkQ   <= 1'b0;
    end else if (strobe.load) begin
      txShift <= strobe.loadByte;
      bitCnt  <= '0;
      halfCnt <= '0;
      sclkQ   <= 1'b0;
    end else if (strobe.run) begin
      if (edgeTick) begin
        halfCnt <= '0;
        if (!sclkQ) begin
          sclkQ   <= 1'b1;
          rxShift <= {rxShift[6:0], miso};
        end else begin
          sclkQ   <= 1'b0;
          txShift <= {txShift[6:0], 1'b0};
          bitCnt  <= bitCnt + 3'd1;
        end
      end else begin
        halfCnt <= halfCnt + HW'(1);
      end
    end
  end

  assign byteDone = edgeTick && sclkQ && (bitCnt == 3'd7);
  assign rxByte   = rxShift;
  assign sclk     = sclkQ;
  assign mosi     = txShift[7];

  // R7: outgoing bit holds through the whole high phase
  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ && $past(sclkQ)) |-> $stable(txShift[7]))
    else $error("mosi moved while sclk high");

  // R8: a rising sclk edge only comes from a running divider
  assert_rise_from_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkQ) |-> $past(strobe.run))
    else $error("sclk rose without run");

endmodule

// File: rtl/sfm_ctrl.sv
module sfm_ctrl
  import sfm_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [15:0]      reqAddr,
  input  logic [4:0]       reqBlock,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [7:0]       rdData,
  output logic             lenError,
  output logic             busy,
  output logic             csN,
  output sfmStrobe_t       strobe,
  input  logic             byteDone,
  input  logic [7:0]       rxByte
);

  localparam int GW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [1:0] HDR_LAST = 2'(HDR_BYTES);

  sfmState_t        state;
  logic [15:0]      addrQ;
  logic [4:0]       blockQ;
  logic             writeQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] remain;
  logic [1:0]       hdrIdx;
  logic [GW-1:0]    gapCnt;
  logic             csNQ;
  logic             rdValidQ;
  logic [7:0]       rdDataQ;
  logic             lenErrQ;
  logic [7:0]       hdrByte;
  logic [1:0]       lenMode;
  logic             inData;

  assign lenMode = (lenQ == LEN_W'(1)) ? MODE_SINGLE : MODE_BURST;
  assign inData  = (hdrIdx == HDR_LAST);

  always_comb begin
    case (hdrIdx)
      2'd0:    hdrByte = addrQ[15:8];
      2'd1:    hdrByte = addrQ[7:0];
      default: hdrByte = {blockQ, writeQ, lenMode};
    endcase
  end

  always_comb begin
    strobe  = '0;
    wrReady = 1'b0;
    case (state)
      ST_NEXT: begin
        if (!inData) begin
          strobe.load     = 1'b1;
          strobe.loadByte = hdrByte;
        end else if (remain != '0 && !writeQ) begin
          strobe.load     = 1'b1;
          strobe.loadByte = 8'h00;
        end
      end
      ST_WAITWR: begin
        wrReady = 1'b1;
        if (wrValid) begin
          strobe.load     = 1'b1;
          strobe.loadByte = wrData;
        end
      end
      ST_SHIFT: strobe.run = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      addrQ    <= '0;
      blockQ   <= '0;
      writeQ   <= 1'b0;
      lenQ     <= '0;
      remain   <= '0;
      hdrIdx   <= '0;
      gapCnt   <= '0;
      csNQ     <= 1'b1;
      rdValidQ <= 1'b0;
      rdDataQ  <= '0;
      lenErrQ  <= 1'b0;
    end else begin
      lenErrQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqLen == '0) begin
              lenErrQ <= 1'b1;
            end else begin
              addrQ  <= reqAddr;
              blockQ <= reqBlock;
              writeQ <= reqWrite;
              lenQ   <= reqLen;
              remain <= reqLen;
              hdrIdx <= '0;
              csNQ   <= 1'b0;
              state  <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          if (!inData) begin
            state <= ST_SHIFT;
          end else if (remain == '0) begin
            csNQ   <= 1'b1;
            gapCnt <= '0;
            state  <= ST_GAP;
          end else if (writeQ) begin
            state <= ST_WAITWR;
          end else begin
            state <= ST_SHIFT;
          end
        end
        ST_WAITWR: begin
          if (wrValid) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (byteDone) begin
            if (!inData) begin
              hdrIdx <= hdrIdx + 2'd1;
              state  <= ST_NEXT;
            end else begin
              remain <= remain - LEN_W'(1);
              if (!writeQ) begin
                rdDataQ  <= rxByte;
                rdValidQ <= 1'b1;
                state    <= ST_RDOUT;
              end else begin
                state <= ST_NEXT;
              end
            end
          end
        end
        ST_RDOUT: begin
          if (rdReady) begin
            rdValidQ <= 1'b0;
            state    <= ST_NEXT;
          end
        end
        ST_GAP: begin
          gapCnt <= gapCnt + GW'(1);
          if (gapCnt == GW'(CLK_DIV - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign csN      = csNQ;
  assign rdValid  = rdValidQ;
  assign rdData   = rdDataQ;
  assign lenError = lenErrQ;

  // R1: chip select low only inside a busy window
  assert_cs_in_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    !csNQ |-> (state != ST_IDLE))
    else $error("csN low while idle");

  // R4: write bytes only requested inside an open frame
  assert_wr_framed_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !csNQ)
    else $error("wrReady outside frame");

  // R5: read byte held until consumed
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidQ && !rdReady) |=> (rdValidQ && $stable(rdDataQ)))
    else $error("read byte dropped");

  // R6: error pulse never coincides with an open frame
  assert_no_frame_on_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    lenErrQ |-> (csNQ && $past(csNQ)))
    else $error("zero-length request opened a frame");

  // R9: trailing idle period runs with chip select released
  assert_gap_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> csNQ)
    else $error("csN low during idle period");

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int LEN_W   = 16,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [15:0]      reqAddr,
  input  logic [4:0]       reqBlock,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [7:0]       wrData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [7:0]       rdData,
  output logic             lenError,
  output logic             busy,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);

  sfm_pkg::sfmStrobe_t strobe;
  logic                byteDone;
  logic [7:0]          rxByte;

  sfm_ctrl #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqBlock(reqBlock), .reqWrite(reqWrite), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .lenError(lenError), .busy(busy), .csN(csN),
    .strobe(strobe), .byteDone(byteDone), .rxByte(rxByte)
  );

  sfm_datapath #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .miso(miso),
    .sclk(sclk), .mosi(mosi), .byteDone(byteDone), .rxByte(rxByte)
  );

endmodule

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;

  localparam int LEN_W   = 16;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [15:0]      reqAddr = '0;
  logic [4:0]       reqBlock = '0;
  logic             reqWrite = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic             wrValid = 1'b0;
  logic             wrReady;
  logic [7:0]       wrData = '0;
  logic             rdValid;
  logic             rdReady = 1'b0;
  logic [7:0]       rdData;
  logic             lenError;
  logic             busy;
  logic             csN;
  logic             sclk;
  logic             mosi;
  logic             miso = 1'b0;

  always #2 clk = ~clk;

  spi_frame_master #(.LEN_W(LEN_W), .CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqBlock(reqBlock), .reqWrite(reqWrite), .reqLen(reqLen),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
    .lenError(lenError), .busy(busy), .csN(csN),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural slave: decodes header, stores writes, answers reads.
  logic [7:0] slaveMem [64];
  logic [7:0] refMem   [64];
  logic [7:0] sHdr     [3];
  logic [7:0] sCur = '0;
  int         sBits = 0;
  int         sBytes = 0;

  always @(negedge csN or posedge sclk) begin
    if (!sclk) begin
      sBits  = 0;
      sBytes = 0;
      miso   = 1'b0;
    end else begin
      sCur = {sCur[6:0], mosi};
      sBits++;
      if (sBits % 8 == 0) begin
        if (sBytes < 3) sHdr[sBytes] = sCur;
        else if (sHdr[2][2]) slaveMem[(int'(sHdr[1]) + sBytes - 3) % 64] = sCur;
        sBytes++;
      end
      if (sBytes >= 3 && !sHdr[2][2])
        miso = slaveMem[(int'(sHdr[1]) + sBytes - 3) % 64][7 - (sBits % 8)];
      else
        miso = 1'b0;
    end
  end

  // Bus timing monitors
  logic prevSclk = 1'b0;
  logic prevMosi = 1'b0;
  int   hiCnt = 0, loCnt = 1000, badHi = 0, badLo = 0, badMosi = 0, badCs = 0, gapRun = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclk && !prevSclk) begin
        if (csN) badCs++;
        if (loCnt < HALF) badLo++;
        loCnt = 0;
      end
      if (!sclk && prevSclk) begin
        if (hiCnt != HALF) badHi++;
        hiCnt = 0;
      end
      if (sclk && prevSclk && mosi != prevMosi) badMosi++;
      if (sclk) hiCnt++; else loCnt++;
      if (csN && busy) gapRun++;
      else if (!busy && gapRun != 0) begin
        check(gapRun == CLK_DIV, "R9 idle period after csN rise", gapRun, CLK_DIV);
        gapRun = 0;
      end
      prevSclk = sclk;
      prevMosi = mosi;
    end
  end

  logic [7:0] wbuf [16];

  task automatic runTxn(input logic wr, input logic [15:0] addr, input logic [4:0] blk,
                        input int len, input int stall);
    int base;
    logic [7:0] expCtrl;
    base = int'(addr[7:0]);
    expCtrl = {blk, wr, (len == 1) ? 2'b01 : 2'b00};
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqBlock = blk; reqLen = LEN_W'(len);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(!csN && busy && !reqReady, "R1 frame open, request port closed",
          {csN, busy, reqReady}, 3'b010);
    if (wr) begin
      for (int k = 0; k < len; k++) begin
        repeat (stall) @(negedge clk);
        wrValid = 1'b1; wrData = wbuf[k];
        while (!wrReady) @(negedge clk);
        @(negedge clk);
        wrValid = 1'b0;
      end
    end else begin
      for (int k = 0; k < len; k++) begin
        while (!rdValid) @(negedge clk);
        check(rdData == refMem[(base + k) % 64], "R5 read byte", rdData, refMem[(base + k) % 64]);
        repeat (stall) @(negedge clk);
        check(rdValid && rdData == refMem[(base + k) % 64], "R5 read byte held",
              {rdValid, rdData}, {1'b1, refMem[(base + k) % 64]});
        rdReady = 1'b1;
        @(negedge clk);
        rdReady = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    check(reqReady, "R9 request port reopens", reqReady, 1);
    check(sHdr[0] == addr[15:8], "R2 address high byte", sHdr[0], addr[15:8]);
    check(sHdr[1] == addr[7:0], "R2 address low byte", sHdr[1], addr[7:0]);
    check(sHdr[2] == expCtrl, "R3 control byte", sHdr[2], expCtrl);
    check(sBits == 8 * (3 + len), "R1 frame bit count", sBits, 8 * (3 + len));
    if (wr) begin
      for (int k = 0; k < len; k++) begin
        check(slaveMem[(base + k) % 64] == wbuf[k], "R4 written byte order",
              slaveMem[(base + k) % 64], wbuf[k]);
        refMem[(base + k) % 64] = wbuf[k];
      end
    end
  endtask

  task automatic zeroLenTxn();
    int bitsBefore;
    int opened;
    bitsBefore = sBits;
    opened = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0042; reqLen = '0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(lenError && csN, "R6 error pulse, no chip select", {lenError, csN}, 2'b11);
    @(negedge clk);
    check(!lenError, "R6 error pulse one cycle", lenError, 0);
    repeat (2 * CLK_DIV) begin
      @(negedge clk);
      if (!csN || busy || sclk) opened++;
    end
    check(opened == 0, "R6 no frame started", opened, 0);
    check(sBits == bitsBefore, "R6 no sclk edges", sBits, bitsBefore);
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd7411);
    for (int i = 0; i < 64; i++) begin
      slaveMem[i] = 8'((i * 37 + 5) & 255);
      refMem[i]   = 8'((i * 37 + 5) & 255);
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN && !sclk && !busy && reqReady && !lenError && !rdValid && !wrReady,
          "R1 reset state", {csN, sclk, busy, reqReady, lenError, rdValid, wrReady}, 7'b1001000);

    // Directed corner cases
    wbuf[0] = 8'hA5;
    runTxn(1'b1, 16'h1234, 5'h0A, 1, 0);     // R3 single write -> low bits 101
    runTxn(1'b0, 16'h1234, 5'h0A, 1, 2);     // R3 single read -> low bits 001
    for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'hF0 + k);
    runTxn(1'b1, 16'hBE3C, 5'h1F, 8, 3);     // R4 burst crossing slave memory end
    runTxn(1'b0, 16'hBE3C, 5'h1F, 8, 1);     // R5 burst read-back with stalls
    zeroLenTxn();                            // R6
    runTxn(1'b0, 16'hFFFF, 5'h00, 2, 0);     // R5 read with no stall

    // Random mix
    for (int t = 0; t < 40; t++) begin
      logic wr;
      int   len;
      wr  = 1'($urandom_range(0, 1));
      len = $urandom_range(1, 8);
      for (int k = 0; k < len; k++) wbuf[k] = 8'($urandom);
      runTxn(wr, 16'($urandom), 5'($urandom), len, $urandom_range(0, 3));
    end

    check(badMosi == 0, "R7 mosi stable while sclk high", badMosi, 0);
    check(badCs == 0, "R1 sclk rise with csN high", badCs, 0);
    check(badHi == 0, "R8 sclk high phase length", badHi, 0);
    check(badLo == 0, "R8 sclk low phase minimum", badLo, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule